// File: doc/BRIEF.md
# Stack Frame Link/Unlink Unit

This block runs the two short micro-sequences that open and close a subroutine stack frame. A caller supplies the current stack pointer, the current value of the register chosen as frame pointer, and a displacement. It then pulses start with an operation select. The unit talks to memory through a single-word request/acknowledge port. It reports the new stack pointer and the new frame-pointer value together with a one-cycle done pulse.

Link pushes the old frame pointer, makes the frame pointer point at that saved word, and moves the stack pointer by the displacement so that local space is reserved. Unlink is the inverse. The stack pointer is reloaded from the frame pointer, the saved frame pointer is popped, and the stack pointer steps past the popped word. The chosen frame register may be the stack pointer itself. In that case every step works on the single shared register, and each step sees the value left by the step before it.

Top module: `lu_frame_unit`

## Requirements
- R1: Link issues exactly one memory write (mem_we_o=1). The write goes to address sp_i-4 and carries the old frame value: fp_i, or sp_i when self_i=1.
- R2: With self_i=0, link finishes with fp_o equal to sp_i-4.
- R3: With self_i=0, link finishes with sp_o equal to sp_i-4 plus the extended displacement.
- R4: When disp_wide_i=1 the displacement is all 32 bits of disp_i. When disp_wide_i=0 it is disp_i[15:0] sign-extended from bit 15, and disp_i[31:16] is ignored.
- R5: Unlink issues exactly one memory read (mem_we_o=0) at the frame value: fp_i, or sp_i when self_i=1.
- R6: With self_i=0, unlink finishes with fp_o equal to the word read and sp_o equal to the frame value plus 4.
- R7: With self_i=1, link finishes with sp_o=fp_o=sp_i-4+displacement. Unlink with self_i=1 finishes with sp_o=fp_o=read word+4.
- R8: A memory request stays asserted with stable address, direction and write data until mem_ack_i is seen. No register update and no done pulse happens before that acknowledge.
- R9: done_o is high for exactly one cycle, the cycle after the acknowledged access. busy_o is high from the cycle after an accepted start until done. A start seen while busy_o=1 is ignored.
- R10: After reset the unit is idle: no request, no done, busy_o=0, sp_o=fp_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_unlink_i | input | 1 | 0 = link, 1 = unlink |
| self_i | input | 1 | Frame register is the stack pointer |
| disp_wide_i | input | 1 | 1 = 32-bit displacement, 0 = 16-bit |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame-register value |
| disp_i | input | 32 | Link displacement |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | New stack pointer |
| fp_o | output | 32 | New frame-register value |

## Verification
The bench sweeps both operations, with the frame register either distinct from or aliased to the stack pointer. It uses both displacement widths and six displacements: zero, small positive and negative values, the largest and smallest 16-bit values, and a value with junk in the upper half. Acknowledge latency runs from zero to two wait cycles. The junk upper half shows whether narrow mode truly sign-extends. The aliased cases show whether each step reads the result of the step before it. The wait cycles, with an extra start injected during the wait, show whether updates are held back for the acknowledge and whether the unit ignores starts while busy.

// File: rtl/lu_pkg.sv
package lu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2,
    ST_DONE = 2'd3
  } lu_state_e;
endpackage

// File: rtl/lu_disp_ext.sv
module lu_disp_ext #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16
) (
  input  logic         wide_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] ext_o
);
  generate
    if (NW >= W) begin : g_pass
      assign ext_o = raw_i;
    end else begin : g_ext
      logic [W-1:0] narrow;
      assign narrow = {{(W-NW){raw_i[NW-1]}}, raw_i[NW-1:0]};
      assign ext_o  = wide_i ? raw_i : narrow;
    end
  endgenerate
endmodule

// File: rtl/lu_seq.sv
module lu_seq
  import lu_pkg::*;
#(
  parameter int unsigned W          = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_unlink_i,
  input  logic         self_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] fp_i,
  input  logic [W-1:0] disp_i,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic [W-1:0] mem_rdata_i,
  input  logic         mem_ack_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] fp_o
);
  localparam logic [W-1:0] STEP = W'(WORD_BYTES);

  lu_state_e    state_q;
  logic [W-1:0] sp_q, fp_q, disp_q;
  logic         self_q;
  logic [W-1:0] fp_eff;

  assign fp_eff = self_i ? sp_i : fp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      fp_q    <= '0;
      disp_q  <= '0;
      self_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          self_q <= self_i;
          disp_q <= disp_i;
          fp_q   <= fp_eff;
          if (op_unlink_i) begin
            sp_q    <= fp_eff;
            state_q <= ST_POP;
          end else begin
            sp_q    <= sp_i - STEP;
            state_q <= ST_PUSH;
          end
        end
        ST_PUSH: if (mem_ack_i) begin
          // frame reg takes pre-displacement sp unless aliased to sp
          fp_q    <= self_q ? (sp_q + disp_q) : sp_q;
          sp_q    <= sp_q + disp_q;
          state_q <= ST_DONE;
        end
        ST_POP: if (mem_ack_i) begin
          if (self_q) begin
            sp_q <= mem_rdata_i + STEP;
            fp_q <= mem_rdata_i + STEP;
          end else begin
            fp_q <= mem_rdata_i;
            sp_q <= sp_q + STEP;
          end
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_PUSH) || (state_q == ST_POP);
  assign mem_we_o    = (state_q == ST_PUSH);
  assign mem_addr_o  = sp_q;
  assign mem_wdata_o = fp_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign sp_o        = sp_q;
  assign fp_o        = fp_q;

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o) &&
                                !done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R9
  done_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> done_o && !mem_req_o);
  // R1
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !op_unlink_i |=>
      mem_req_o && mem_we_o && mem_addr_o == $past(sp_i) - STEP);
  // R2
  link_fp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i && !self_q |=> fp_o == $past(mem_addr_o));
  // R6
  unlink_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i && !self_q |=>
      fp_o == $past(mem_rdata_i) && sp_o == $past(mem_addr_o) + STEP);
endmodule

// File: rtl/lu_frame_unit.sv
module lu_frame_unit #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NARROW_W   = 16,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_unlink_i,
  input  logic              self_i,
  input  logic              disp_wide_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] fp_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] fp_o
);
  logic [ADDR_W-1:0] disp_ext;

  lu_disp_ext #(.W(ADDR_W), .NW(NARROW_W)) u_ext (
    .wide_i (disp_wide_i),
    .raw_i  (disp_i),
    .ext_o  (disp_ext)
  );

  lu_seq #(.W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_unlink_i (op_unlink_i),
    .self_i      (self_i),
    .sp_i        (sp_i),
    .fp_i        (fp_i),
    .disp_i      (disp_ext),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sp_o        (sp_o),
    .fp_o        (fp_o)
  );
endmodule

// File: tb/lu_frame_unit_tb.sv
`timescale 1ns/1ps
module lu_frame_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_unlink = 1'b0, self_sel = 1'b0, wide = 1'b0;
  logic [31:0] sp = '0, fp = '0, disp = '0, rdata = '0;
  logic        ack = 1'b0;
  logic        req, we, busy, done;
  logic [31:0] addr, wdata, sp_out, fp_out;
  int          total = 0, bad = 0;
  logic        wd_hit = 1'b0;

  always #2 clk = ~clk;

  lu_frame_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_unlink_i(op_unlink),
    .self_i(self_sel), .disp_wide_i(wide), .sp_i(sp), .fp_i(fp), .disp_i(disp),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .busy_o(busy), .done_o(done),
    .sp_o(sp_out), .fp_o(fp_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] disp_pick(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0010;
      2: return 32'hFFFF_FFF0;
      3: return 32'h0000_7FFC;
      4: return 32'h0000_8000;
      default: return 32'hABCD_FFF8;
    endcase
  endfunction

  task automatic run_op(input logic un, input logic sf, input logic wd,
                        input logic [31:0] d, input int dly, input int seed);
    logic [31:0] sp0, fp0, fpv, ext, rd, e_addr, e_sp, e_fp;
    logic [31:0] a0, w0;
    logic        we0, seen, unstable;
    int          cnt, nacc, guard;
    sp0 = 32'h0001_0000 + 32'(seed) * 32'h40;
    fp0 = 32'h0002_0000 + 32'(seed) * 32'h24;
    rd  = 32'h00C0_0000 ^ (32'(seed) * 32'h1_0001);
    fpv = sf ? sp0 : fp0;
    ext = wd ? d : {{16{d[15]}}, d[15:0]};
    if (!un) begin
      e_addr = sp0 - 32'd4;
      e_sp   = sp0 - 32'd4 + ext;
      e_fp   = sf ? e_sp : sp0 - 32'd4;
    end else begin
      e_addr = fpv;
      e_sp   = sf ? rd + 32'd4 : fpv + 32'd4;
      e_fp   = sf ? rd + 32'd4 : rd;
    end
    @(negedge clk);
    op_unlink = un; self_sel = sf; wide = wd; disp = d; sp = sp0; fp = fp0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", {31'd0, busy}, 32'd1);
    cnt = 0; nacc = 0; seen = 1'b0; unstable = 1'b0; guard = 0;
    a0 = '0; w0 = '0; we0 = 1'b0;
    while (!done && guard < 50) begin
      if (req) begin
        if (!seen) begin a0 = addr; w0 = wdata; we0 = we; seen = 1'b1; end
        else if (addr !== a0 || wdata !== w0 || we !== we0) unstable = 1'b1;
        if (cnt == dly) begin ack = 1'b1; rdata = rd; nacc++; end
        else begin
          // stray start while busy: opposite op, other operands
          start = (cnt == 0); op_unlink = ~un; sp = 32'hDEAD_0000; fp = 32'hBEEF_0000;
        end
        cnt++;
      end
      @(negedge clk);
      ack = 1'b0; start = 1'b0; rdata = 32'h5555_5555;
      guard++;
    end
    chk("R8 done reached", {31'd0, done}, 32'd1);
    chk(un ? "R5 access addr" : "R1 access addr", a0, e_addr);
    chk(un ? "R5 direction" : "R1 direction", {31'd0, we0}, {31'd0, ~un});
    if (!un) chk("R1 write data", w0, fpv);
    chk("R8 request stable", {31'd0, unstable}, 32'd0);
    chk("R9 single access", 32'(nacc), 32'd1);
    chk(sf ? "R7 sp" : (un ? "R6 sp" : (wd ? "R3 sp" : "R4 sp")), sp_out, e_sp);
    chk(sf ? "R7 fp" : (un ? "R6 fp" : "R2 fp"), fp_out, e_fp);
    @(negedge clk);
    chk("R9 done one cycle", {30'd0, done, busy}, 32'd0);
    chk("R9 no restart", {31'd0, req}, 32'd0);
  endtask

  initial begin
    #1000000;
    wd_hit = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 req", {31'd0, req}, 32'd0);
    chk("R10 done/busy", {30'd0, done, busy}, 32'd0);
    chk("R10 sp", sp_out, 32'd0);
    chk("R10 fp", fp_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int un = 0; un < 2 && !wd_hit; un++)
      for (int sf = 0; sf < 2; sf++)
        for (int wd = 0; wd < 2; wd++)
          for (int dl = 0; dl < 3; dl++)
            for (int k = 0; k < 6; k++)
              run_op(un[0], sf[0], wd[0], disp_pick(k), dl, k + dl * 7 + wd * 31);
    if (wd_hit) begin
      total++; bad++;
      $display("FAIL watchdog act=expired exp=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule